// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous static memory. Reads and writes share one fixed rhythm. A command and its address are captured on one rising edge, and the data for that command uses the bus two edges later. For a read, the bus carries the word in the cycle that follows the second edge. For a write, the controller drives the word during that same cycle, and the memory captures it on the third edge. Because both directions keep the same spacing, a controller can mix reads and writes on consecutive cycles with no idle cycle between them.

The memory has a global clock enable and a sleep input, and either one freezes the whole pipeline. Three chip selects of mixed polarity decide whether a load starts an access or a deselect. An advance mode repeats the last access at the next address in a four-word group that wraps around. The bus is split into an input net, an output net and a drive-enable net. The drive enable comes from the pipeline and is masked at once by an asynchronous output enable. The word is divided into byte lanes of nine bits, and each lane has its own write strobe.

Top module: `zbt_sram`

## Requirements
- R1: A read loaded on edge n (adv_ld=0, selected, wr_n=1) drives the stored word on dq_out with dq_oe=1 in the cycle after edge n+2, provided oe_n=0.
- R2: A write loaded on edge n (adv_ld=0, selected, wr_n=0) takes its data from dq_in at edge n+3, which is the edge that ends the cycle after edge n+2.
- R3: Lane k is dq bits [9k+8:9k]. Lane k is written only when bw_n[k]=0 is sampled with the write command; the other lanes of the word keep their contents.
- R4: When wr_n=1 the byte strobes have no effect, and a read never changes the memory.
- R5: Reads and writes can be issued on consecutive edges in any mix with no idle cycle. A read of an address whose write is in its data-capture edge returns the newly written lanes.
- R6: With cen_n=1 at an edge, all inputs are ignored and the pipeline state, dq_out and dq_oe stay as they were.
- R7: With sleep=1 at an edge, the block behaves as in R6 and the memory contents are kept.
- R8: A load starts an access only when ce1_n=0, ce2=1 and ce3_n=0. Otherwise a load starts a deselect: it performs no access, accesses already issued still finish, and dq_oe is low two edges later.
- R9: oe_n=1 forces dq_oe low without waiting for a clock edge.
- R10: dq_oe is never high during the data cycle of a write, even when oe_n=0.
- R11: With adv_ld=1, the last loaded access (read or write) repeats at its address with bits [1:0] incremented modulo 4, using the strobes sampled at that edge. After a deselect, advance stays deselected.
- R12: After reset all pipeline stages are idle and dq_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| cen_n | input | 1 | Active-low clock enable |
| sleep | input | 1 | High gates the internal clock |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the last one |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 1 read, 0 write |
| addr | input | AW | Word address |
| bw_n | input | NL | Active-low lane write strobes |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | NL*9 | Write data from the bus |
| dq_out | output | NL*9 | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A stage that is misplaced or skipped in the pipeline shows up in the read data or in the dq_oe window, shifted by one cycle, on the first read that follows it. A strobe or address that is corrupted in a stage does not show at once. It shows only when a later read returns that word, which may be many cycles after the write. A freeze that lets state leak forward shows within one enabled edge, because the next data cycle then comes early.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    localparam int unsigned LANE_W  = 9;
    localparam int unsigned BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe
    import zbt_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned NL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load_n,
    input  logic          sel_ok,
    input  logic          wr_n,
    input  logic [AW-1:0] addr_in,
    input  logic [NL-1:0] bw_n_in,
    output logic          rd_go,
    output logic [AW-1:0] rd_addr,
    output logic          wr_go,
    output logic [AW-1:0] wr_addr,
    output logic [NL-1:0] wr_bw_n,
    output logic          drive_phase
);
    typedef struct packed {
        op_e           op;
        logic [AW-1:0] addr;
        logic [NL-1:0] bw_n;
    } entry_t;

    typedef struct packed {
        entry_t s1;
        entry_t s2;
        entry_t s3;
    } pipe_t;

    localparam entry_t IDLE_ENTRY = '{op: OP_IDLE, addr: '0, bw_n: '1};
    localparam pipe_t  PIPE_RESET = '{s1: IDLE_ENTRY, s2: IDLE_ENTRY, s3: IDLE_ENTRY};

    pipe_t pipe_d, pipe_q;

    function automatic logic [AW-1:0] burst_next(input logic [AW-1:0] a);
        logic [AW-1:0] n;
        n = a;
        n[BURST_W-1:0] = a[BURST_W-1:0] + {{(BURST_W-1){1'b0}}, 1'b1};
        return n;
    endfunction

    always_comb begin
        pipe_d = pipe_q;
        if (step) begin
            pipe_d.s3 = pipe_q.s2;
            pipe_d.s2 = pipe_q.s1;
            if (!load_n) begin
                if (sel_ok) begin
                    pipe_d.s1.op   = wr_n ? OP_READ : OP_WRITE;
                    pipe_d.s1.addr = addr_in;
                    pipe_d.s1.bw_n = wr_n ? '1 : bw_n_in;
                end else begin
                    pipe_d.s1 = IDLE_ENTRY;
                end
            end else if (pipe_q.s1.op != OP_IDLE) begin
                pipe_d.s1.addr = burst_next(pipe_q.s1.addr);
                pipe_d.s1.bw_n = (pipe_q.s1.op == OP_WRITE) ? bw_n_in : '1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= PIPE_RESET;
        else        pipe_q <= pipe_d;
    end

    assign rd_go       = (pipe_q.s2.op == OP_READ);
    assign rd_addr     = pipe_q.s2.addr;
    assign wr_go       = (pipe_q.s3.op == OP_WRITE);
    assign wr_addr     = pipe_q.s3.addr;
    assign wr_bw_n     = pipe_q.s3.bw_n;
    assign drive_phase = (pipe_q.s3.op == OP_READ);

    // R6 and R7: a held edge leaves every stage untouched
    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pipe_q));

    // R1 and R2: entries advance one stage per enabled edge
    assert_stage_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (pipe_q.s3 == $past(pipe_q.s2)) && (pipe_q.s2 == $past(pipe_q.s1)));

    assert_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_n && !sel_ok) |=> (pipe_q.s1.op == OP_IDLE));
endmodule

// File: rtl/zbt_array.sv
module zbt_array
    import zbt_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned NL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               rd_go,
    input  logic [AW-1:0]      rd_addr,
    input  logic               wr_go,
    input  logic [AW-1:0]      wr_addr,
    input  logic [NL-1:0]      wr_bw_n,
    input  logic [NL*LANE_W-1:0] wdata,
    output logic [NL*LANE_W-1:0] rdata
);
    localparam int unsigned DW    = NL * LANE_W;
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] merged;
    logic [DW-1:0] old_word;
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        merged = mem[rd_addr];
        if (wr_go && (wr_addr == rd_addr)) begin
            for (int k = 0; k < NL; k++) begin
                if (!wr_bw_n[k]) merged[k*LANE_W +: LANE_W] = wdata[k*LANE_W +: LANE_W];
            end
        end
        rdata_d = rdata_q;
        if (step && rd_go) rdata_d = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    for (genvar k = 0; k < NL; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (step && wr_go && !wr_bw_n[k])
                mem[wr_addr][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
        end

        assert_lane_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (step && wr_go && !wr_bw_n[k]) |=>
                mem[$past(wr_addr)][k*LANE_W +: LANE_W] == $past(wdata[k*LANE_W +: LANE_W]));

        assert_lane_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (step && wr_go && wr_bw_n[k]) |=>
                mem[$past(wr_addr)][k*LANE_W +: LANE_W] == $past(old_word[k*LANE_W +: LANE_W]));
    end

    assign old_word = mem[wr_addr];
    assign rdata    = rdata_q;

    assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rd_go && wr_go && (rd_addr == wr_addr) && (wr_bw_n == '0)) |=>
            (rdata_q == $past(wdata)));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned NL = 4,
    localparam int unsigned DW = NL * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cen_n,
    input  logic          sleep,
    input  logic          adv_ld,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [NL-1:0] bw_n,
    input  logic          oe_n,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    logic          step;
    logic          sel_ok;
    logic          rd_go, wr_go, drive_phase;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [NL-1:0] wr_bw_n;

    assign step   = ~cen_n & ~sleep;
    assign sel_ok = ~ce1_n & ce2 & ~ce3_n;

    zbt_cmd_pipe #(.AW(AW), .NL(NL)) i_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .load_n     (adv_ld),
        .sel_ok     (sel_ok),
        .wr_n       (wr_n),
        .addr_in    (addr),
        .bw_n_in    (bw_n),
        .rd_go      (rd_go),
        .rd_addr    (rd_addr),
        .wr_go      (wr_go),
        .wr_addr    (wr_addr),
        .wr_bw_n    (wr_bw_n),
        .drive_phase(drive_phase)
    );

    zbt_array #(.AW(AW), .NL(NL)) i_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .rd_go  (rd_go),
        .rd_addr(rd_addr),
        .wr_go  (wr_go),
        .wr_addr(wr_addr),
        .wr_bw_n(wr_bw_n),
        .wdata  (dq_in),
        .rdata  (dq_out)
    );

    assign dq_oe = ~oe_n & drive_phase;

    assert_no_drive_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> !dq_oe);
endmodule

// File: tb/test_zbt_sram.sv
module test_zbt_sram;
    localparam int AW = 10;
    localparam int NL = 4;
    localparam int DW = 36;
    localparam int DEPTH = 1 << AW;
    localparam logic [1:0] M_IDLE = 2'd0, M_RD = 2'd1, M_WR = 2'd2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cen_n = 1'b1, sleep = 1'b0, adv_ld = 1'b0;
    logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] bw_n = '1;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    zbt_sram #(.AW(AW), .NL(NL)) i_zbt_sram (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sleep(sleep), .adv_ld(adv_ld),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .wr_n(wr_n), .addr(addr),
        .bw_n(bw_n), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] a;
        logic [NL-1:0] bw;
    } ent_t;

    ent_t          m1, m2, m3;
    logic [DW-1:0] ref_mem [DEPTH];
    bit            known [DEPTH];
    logic [DW-1:0] m_rdata;
    bit            m_rdata_known;
    int            checks = 0;
    int            failures = 0;
    string         tag = "R12";
    bit            done = 1'b0;

    task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s [%s] actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, check before the edge, update the model at the edge
    task automatic cyc(input bit cn, input bit slp, input bit adv, input bit c1n, input bit c2,
                       input bit c3n, input bit wn, input int a, input logic [NL-1:0] bw, input bit oen);
        logic [63:0] r;
        logic [DW-1:0] din;
        bit exp_oe;
        ent_t nx;
        r = {$urandom(), $urandom()};
        din = r[DW-1:0];
        cen_n = cn; sleep = slp; adv_ld = adv; ce1_n = c1n; ce2 = c2; ce3_n = c3n;
        wr_n = wn; addr = AW'(a); bw_n = bw; oe_n = oen; dq_in = din;
        #1;
        exp_oe = !oen && (m3.op == M_RD);
        chk(dq_oe == exp_oe, "R1 R9 R10 drive enable", {35'd0, dq_oe}, {35'd0, exp_oe});
        if (exp_oe && m_rdata_known)
            chk(dq_out == m_rdata, "R1 read data", dq_out, m_rdata);
        @(posedge clk);
        if (!cn && !slp) begin
            if (m3.op == M_WR) begin
                for (int k = 0; k < NL; k++)
                    if (!m3.bw[k]) ref_mem[m3.a][k*9 +: 9] = din[k*9 +: 9];
                if (m3.bw == '0) known[m3.a] = 1'b1;
            end
            if (m2.op == M_RD) begin
                m_rdata = ref_mem[m2.a];
                m_rdata_known = known[m2.a];
            end
            nx = m1;
            if (!adv) begin
                if (!c1n && c2 && !c3n) begin
                    nx.op = wn ? M_RD : M_WR;
                    nx.a  = AW'(a);
                    nx.bw = wn ? '1 : bw;
                end else begin
                    nx = '{op: M_IDLE, a: '0, bw: '1};
                end
            end else if (m1.op != M_IDLE) begin
                nx.a[1:0] = m1.a[1:0] + 2'd1;
                nx.bw = (m1.op == M_WR) ? bw : '1;
            end
            m3 = m2; m2 = m1; m1 = nx;
        end
        @(negedge clk);
    endtask

    task automatic rd(input int a);
        cyc(0, 0, 0, 0, 1, 0, 1, a, NL'($urandom()), 0);
    endtask
    task automatic wr(input int a, input logic [NL-1:0] bw);
        cyc(0, 0, 0, 0, 1, 0, 0, a, bw, 0);
    endtask
    task automatic nop();
        cyc(0, 0, 0, 1, 1, 0, 1, 0, '1, 0);
    endtask
    task automatic adv(input logic [NL-1:0] bw);
        cyc(0, 0, 1, 0, 1, 0, 1, $urandom_range(0, DEPTH-1), bw, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m1 = '{op: M_IDLE, a: '0, bw: '1}; m2 = m1; m3 = m1;
        m_rdata = '0; m_rdata_known = 0;
        for (int i = 0; i < DEPTH; i++) begin ref_mem[i] = '0; known[i] = 0; end
        repeat (3) @(negedge clk);
        tag = "R12";
        chk(dq_oe == 1'b0, "R12 idle after reset", {35'd0, dq_oe}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        nop();

        tag = "R2";
        for (int i = 0; i < DEPTH; i++) wr(i, '0);
        repeat (3) nop();

        tag = "R1";
        rd(5); rd(6); rd(700); repeat (3) nop();

        tag = "R3";
        wr(7, 4'b1010); repeat (2) nop(); rd(7); repeat (3) nop();
        wr(8, 4'b0111); rd(8); repeat (3) nop();

        tag = "R4";
        rd(9); cyc(0, 0, 0, 0, 1, 0, 1, 9, 4'b0000, 0); rd(9); repeat (3) nop();

        tag = "R5";
        wr(10, '0); rd(10); wr(11, '0); rd(11); rd(10); wr(10, 4'b1100); rd(10);
        rd(12); wr(12, '0); rd(12); repeat (3) nop();

        tag = "R6";
        rd(13); nop(); nop();
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 1, 0, 0, 13, '0, 0);
        repeat (3) nop(); rd(13); repeat (3) nop();

        tag = "R7";
        wr(14, '0); nop();
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 1, 0, 0, 14, '0, 0);
        repeat (3) nop(); rd(14); repeat (3) nop();

        tag = "R8";
        cyc(0, 0, 0, 1, 1, 0, 0, 15, '0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 15, '0, 0);
        cyc(0, 0, 0, 0, 1, 1, 0, 15, '0, 0);
        repeat (3) nop(); rd(15); nop(); nop(); nop();
        rd(16); nop(); cyc(0, 0, 1, 1, 1, 0, 1, 0, '1, 0); repeat (3) nop();

        tag = "R9";
        rd(17); nop(); cyc(0, 0, 0, 1, 1, 0, 1, 0, '1, 1); nop(); nop();

        tag = "R10";
        wr(18, '0); wr(19, '0); cyc(0, 0, 0, 1, 1, 0, 1, 0, '1, 0); nop(); nop();

        tag = "R11";
        rd(22); adv('1); adv('0); adv('1); repeat (3) nop();
        wr(24, '0); adv(4'b1110); adv('0); adv(4'b0111); repeat (3) nop();
        rd(24); rd(25); rd(26); rd(27); repeat (3) nop();
        nop(); adv('0); adv('0); repeat (3) nop();

        tag = "R1 R2 R3 R5 R6 R8 R9 R11";
        for (int i = 0; i < 4000; i++) begin
            int p;
            p = $urandom_range(0, 99);
            cyc(p < 4, (p >= 4 && p < 7), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) != 0), ($urandom_range(0, 15) == 0),
                $urandom_range(0, 1), $urandom_range(0, 31), NL'($urandom()), ($urandom_range(0, 19) == 0));
        end
        repeat (4) nop();

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule